// File: doc/BRIEF.md
# Prioritised Trace Stream Funnel

This block merges up to eight trace input streams into one output stream. Each input presents a data word and a source identifier under a valid/ready handshake. The upstream source wired to each input is fixed when the chip is built. Software can only admit or block an input; it cannot move a source to another input.

An arbiter chooses among the inputs that are both admitted and holding valid data. It uses a programmable 3-bit priority value per input, and the lowest input index breaks a tie. Once an input wins, it keeps the output for a programmable number of accepted transfers. If it runs out of data or is blocked before then, arbitration runs again at once. The selected word and identifier reach the output through one register stage. Two registers, reached through a plain write-enable/address/data port, hold the configuration.

Top module: `trace_funnel`

## Requirements
- R1: After reset, the control word at offset 0x00 reads 0x300 (no input admitted, hold of 3), the priority word at offset 0x04 reads 0xFAC688, out_valid is low and every in_ready bit is low.
- R2: Control bit n (n = 0..7) admits input n. An input whose bit is clear never receives in_ready and never reaches the output, even when it holds valid data.
- R3: When no admitted input holds valid data, out_valid falls and stays low, and no in_ready bit is raised.
- R4: Bits 3n+2 to 3n of the priority word hold the priority of input n. Among admitted, requesting inputs, the one with the numerically smallest value wins.
- R5: When requesting inputs share the smallest priority value, the one with the lowest index wins.
- R6: Control bits 11 to 8 set the hold count H. A winning input keeps the output for H accepted transfers, even against a better-priority request, and arbitration then runs again. A hold field of 0 acts as 1.
- R7: If the held input drops valid, or its admit bit is cleared, arbitration runs at once on the next transfer and does not wait for the hold to expire.
- R8: A word accepted from an input appears on out_data/out_id, with out_valid high, in the cycle after the acceptance edge. While out_valid is high and out_ready is low, the output stays unchanged and no in_ready is raised. At most one in_ready bit is high at any time.
- R9: Register writes take effect at the clock edge where reg_we is sampled. reg_rdata shows the word at reg_addr one cycle after the address is presented. Offsets other than 0x00 and 0x04 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 8 | Per-input data valid |
| in_ready | output | 8 | Per-input acceptance, at most one high |
| in_data | input | 128 | Input n data at bits 16n+15:16n |
| in_id | input | 56 | Input n source ID at bits 7n+6:7n |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream acceptance |
| out_data | output | 16 | Merged data word |
| out_id | output | 7 | Source ID of the merged word |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the address |

## Verification
The hardest case to reach from the ports is a better-priority input that arrives while a weaker input is partway through its hold. Without that case, the hold cannot be told apart from plain priority. The bench raises the weaker input alone for one cycle, then raises the stronger one. It records the identifier of every output beat, so the full order of grants can be compared with the expected one. Early release through a register write is driven at a chosen negative edge, so that the change lands on a known transfer.

// File: rtl/trace_funnel.sv
module trace_funnel #(
  parameter int NPORT = 8,
  parameter int DW    = 16,
  parameter int IW    = 7,
  parameter int PW    = 3,
  parameter int HW    = 4,
  parameter int AW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORT-1:0]    in_valid,
  output logic [NPORT-1:0]    in_ready,
  input  logic [NPORT*DW-1:0] in_data,
  input  logic [NPORT*IW-1:0] in_id,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DW-1:0]       out_data,
  output logic [IW-1:0]       out_id,
  input  logic                reg_we,
  input  logic [AW-1:0]       reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata
);
  localparam int SW  = $clog2(NPORT);
  localparam int PRW = NPORT * PW;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_PRIO = AW'(4);

  function automatic logic [PRW-1:0] prio_reset();
    logic [PRW-1:0] r;
    r = '0;
    for (int i = 0; i < NPORT; i++) r[i*PW +: PW] = PW'(i);
    return r;
  endfunction

  logic [NPORT-1:0] en_q;
  logic [HW-1:0]    hold_q;
  logic [PRW-1:0]   prio_q;

  logic             gnt_vld_q;
  logic [SW-1:0]    gnt_q;
  logic [HW-1:0]    rem_q;

  logic [SW-1:0]    win;
  logic             win_vld;
  logic [PW-1:0]    best;

  wire [NPORT-1:0] req        = in_valid & en_q;
  wire             cur_ok     = gnt_vld_q && req[gnt_q];
  wire [SW-1:0]    sel        = cur_ok ? gnt_q : win;
  wire             sel_vld    = cur_ok || win_vld;
  wire             stage_free = !out_valid || out_ready;
  wire             xfer       = sel_vld && stage_free;
  wire [HW-1:0]    hold_eff   = (hold_q == '0) ? HW'(1) : hold_q;
  wire [HW-1:0]    new_rem    = cur_ok ? rem_q - HW'(1) : hold_eff - HW'(1);

  always_comb begin
    win     = '0;
    win_vld = 1'b0;
    best    = '1;
    for (int i = 0; i < NPORT; i++) begin
      if (req[i] && (!win_vld || prio_q[i*PW +: PW] < best)) begin
        win     = SW'(i);
        best    = prio_q[i*PW +: PW];
        win_vld = 1'b1;
      end
    end
  end

  assign in_ready = xfer ? (NPORT'(1) << sel) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_vld_q <= 1'b0;
      gnt_q     <= '0;
      rem_q     <= '0;
    end else if (xfer) begin
      gnt_q     <= sel;
      rem_q     <= new_rem;
      gnt_vld_q <= (new_rem != '0);
    end else if (!cur_ok) begin
      gnt_vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_id    <= '0;
    end else if (xfer) begin
      out_valid <= 1'b1;
      out_data  <= in_data[sel*DW +: DW];
      out_id    <= in_id[sel*IW +: IW];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= '0;
      hold_q    <= HW'(3);
      prio_q    <= prio_reset();
      reg_rdata <= '0;
    end else begin
      if (reg_we && reg_addr == A_CTRL) begin
        en_q   <= reg_wdata[NPORT-1:0];
        hold_q <= reg_wdata[NPORT +: HW];
      end
      if (reg_we && reg_addr == A_PRIO) prio_q <= reg_wdata[PRW-1:0];
      if (reg_addr == A_CTRL)      reg_rdata <= 32'({hold_q, en_q});
      else if (reg_addr == A_PRIO) reg_rdata <= 32'(prio_q);
      else                         reg_rdata <= '0;
    end
  end

  assert_one_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));

  assert_blocked_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~en_q) == '0);

  assert_idle_no_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_valid & en_q) == '0) |-> (in_ready == '0));

  assert_stall_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_id)));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != A_CTRL && reg_addr != A_PRIO) |=> (reg_rdata == '0));

  assert_accept_to_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready != '0) |=> out_valid);
endmodule

// File: tb/trace_funnel_tb.sv
`timescale 1ns/1ps
module trace_funnel_tb_top;
  localparam int NP = 8, DW = 16, IW = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP-1:0]     in_valid = '0;
  logic [NP-1:0]     in_ready;
  logic [NP*DW-1:0]  in_data;
  logic [NP*IW-1:0]  in_id;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [DW-1:0]     out_data;
  logic [IW-1:0]     out_id;
  logic              reg_we = 1'b0;
  logic [7:0]        reg_addr = 8'h00;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;

  int nchk = 0, nfail = 0;
  int seq [64];
  int nrec = 0;
  bit rec = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trace_funnel dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_id(in_id), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_id(out_id), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  always_comb
    for (int p = 0; p < NP; p++) begin
      in_data[p*DW +: DW] = 16'h5A00 + 16'(p * 16'h11);
      in_id[p*IW +: IW]   = IW'(p);
    end

  always @(negedge clk)
    if (rec && out_valid && out_ready) begin
      if (nrec < 64) seq[nrec] = int'(out_id);
      nrec++;
    end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] pset(input logic [23:0] b, input int p, input int v);
    logic [23:0] r;
    r = b;
    r[p*3 +: 3] = 3'(v);
    return r;
  endfunction

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 8'h00;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic drain();
    in_valid = '0;
    repeat (3) @(negedge clk);
    nrec = 0;
    rec = 1'b1;
  endtask

  task automatic check_seq(input string tag, input logic [31:0] exp, input int k);
    for (int i = 0; i < k; i++)
      check($sformatf("%s beat%0d", tag, i), 32'(seq[i]), 32'(exp[4*i +: 4]));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 out_valid", 32'(out_valid), 0);
    check("R1 in_ready", 32'(in_ready), 0);
    reg_read(8'h00, d); check("R1 ctrl", d, 32'h300);
    reg_read(8'h04, d); check("R1 prio", d, 32'hFAC688);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    reg_write(8'h00, 32'h0A5);
    reg_read(8'h00, d); check("R9 ctrl readback", d, 32'h0A5);
    reg_write(8'h04, 32'h123456);
    reg_read(8'h04, d); check("R9 prio readback", d, 32'h123456);
    reg_read(8'h08, d); check("R9 unmapped", d, 0);
    reg_write(8'h04, 32'hFAC688);
    reg_write(8'h00, 32'h000);
  endtask

  task automatic t_idle();
    drain();
    in_valid = '1;
    repeat (3) @(negedge clk);
    check("R3 out_valid idle", 32'(out_valid), 0);
    check("R3 in_ready idle", 32'(in_ready), 0);
    in_valid = '0;
  endtask

  task automatic t_disabled();
    reg_write(8'h00, 32'h110);
    drain();
    in_valid = 8'h11;
    #0.1;
    check("R2 blocked ready", 32'(in_ready[0]), 0);
    repeat (5) @(negedge clk);
    check_seq("R2 only admitted", 32'h4444, 4);
  endtask

  task automatic t_priority();
    logic [23:0] p;
    p = 24'hFFFFFF; p = pset(p, 5, 1); p = pset(p, 2, 4);
    reg_write(8'h04, 32'(p));
    reg_write(8'h00, 32'h124);
    drain();
    in_valid = 8'h24;
    repeat (5) @(negedge clk);
    check_seq("R4 lower value wins", 32'h555, 3);
  endtask

  task automatic t_tie();
    logic [23:0] p;
    p = 24'hFFFFFF; p = pset(p, 3, 2); p = pset(p, 6, 2);
    reg_write(8'h04, 32'(p));
    reg_write(8'h00, 32'h148);
    drain();
    in_valid = 8'h48;
    repeat (5) @(negedge clk);
    check_seq("R5 tie lowest index", 32'h333, 3);
    reg_write(8'h04, 32'hFAC688);
  endtask

  task automatic t_hold();
    reg_write(8'h00, 32'h305);
    drain();
    in_valid[2] = 1'b1;
    @(negedge clk);
    in_valid[0] = 1'b1;
    repeat (8) @(negedge clk);
    check_seq("R6 hold 3 then rearb", 32'h000222, 6);
  endtask

  task automatic t_hold_zero();
    logic [23:0] p;
    p = pset(24'hFAC688, 3, 0); p = pset(p, 1, 5);
    reg_write(8'h04, 32'(p));
    reg_write(8'h00, 32'h00A);
    drain();
    in_valid[1] = 1'b1;
    @(negedge clk);
    in_valid[3] = 1'b1;
    repeat (6) @(negedge clk);
    check_seq("R6 hold zero acts as one", 32'h3331, 4);
    reg_write(8'h04, 32'hFAC688);
  endtask

  task automatic t_release_valid();
    reg_write(8'h00, 32'hF42);
    drain();
    in_valid = 8'h42;
    @(negedge clk);
    @(negedge clk);
    in_valid[1] = 1'b0;
    repeat (4) @(negedge clk);
    check_seq("R7 release on valid drop", 32'h6611, 4);
  endtask

  task automatic t_release_disable();
    reg_write(8'h00, 32'hF42);
    drain();
    in_valid = 8'h42;
    @(negedge clk);
    @(negedge clk);
    reg_write(8'h00, 32'hF40);
    repeat (4) @(negedge clk);
    check_seq("R7 release on disable", 32'h6111, 4);
  endtask

  task automatic t_stall();
    reg_write(8'h00, 32'h104);
    drain();
    rec = 1'b0;
    out_ready = 1'b0;
    in_valid[2] = 1'b1;
    @(negedge clk);
    check("R8 out_valid after accept", 32'(out_valid), 1);
    check("R8 out_data", 32'(out_data), 32'h5A22);
    check("R8 out_id", 32'(out_id), 2);
    check("R8 no ready while full", 32'(in_ready), 0);
    repeat (3) @(negedge clk);
    check("R8 held during stall", 32'({out_valid, out_data}), 32'h15A22);
    out_ready = 1'b1;
    in_valid = '0;
    repeat (2) @(negedge clk);
    check("R3 out_valid drains", 32'(out_valid), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_idle();
    t_disabled();
    t_priority();
    t_tie();
    t_hold();
    t_hold_zero();
    t_release_valid();
    t_release_disable();
    t_stall();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule